// File: doc/BRIEF.md
# Dual-Channel Triangular Chirp Oscillator

This block is a numerically controlled oscillator that produces a continuous triangular linear-frequency sweep on two sample channels. Both channels share one frequency ramp. A frequency word climbs from a programmed base by a fixed increment, once per dwell interval, until it reaches a programmed number of steps. It then falls back to the base by the same increment and climbs again, with no gap between the two directions. For example, a 200 MHz span built from 4 kHz increments gives 50,000 steps per direction. With a 10 ns dwell on a 100 MHz clock, each direction then takes 0.5 ms and the full triangle takes 1 ms.

The current frequency word is added into a 32-bit phase accumulator on every enabled cycle. Each channel adds its own 16-bit phase offset to the upper bits of the accumulator. The top bits of the result address a quarter-wave-symmetric sine approximation, which gives registered 12-bit two's-complement samples. The two outputs therefore carry the same chirp, shifted by a constant phase. A new offset is adopted only at restart or when the ramp comes back to its base, so the phase difference never jumps in the middle of a sweep. A synchronous restart input loads a new sweep configuration and clears the phase.

Top module: `dual_chirp_nco`

## Requirements
- R1: After reset, freq_word is 0, dir_up is 1, both samples are 0 and the phase accumulator is 0. The ramp is idle (zero step count) until the first restart.
- R2: On a cycle with restart high, the block captures start_freq, step_freq, step_count, phase_a and phase_b. On the following cycle, freq_word equals the captured start, dir_up is 1, the accumulator is 0 and the dwell counter is restarted. This happens whether or not en is high.
- R3: With a step count N > 0, successive frequency values are start + k*step modulo 2^32 for k = 0,1,...,N,N-1,...,1,0,1,... Each extreme (k = N and k = 0) is held for one dwell only and is not repeated.
- R4: The frequency word changes only after DWELL enabled cycles at its current value. The first step after restart comes after DWELL enabled cycles.
- R5: dir_up is 1 while the sweep rises. It goes to 0 on the cycle freq_word reaches k = N, and it returns to 1 on the cycle freq_word returns to k = 0.
- R6: While en is low (and restart is low), freq_word, dir_up, the dwell progress and the phase accumulator hold.
- R7: With a step count of 0, freq_word stays at the start value and dir_up stays 1.
- R8: On each enabled cycle, the accumulator advances by the freq_word value present in that cycle, modulo 2^32. Both channels use this same accumulator.
- R9: The phase of a channel is the accumulator plus its latched 16-bit offset shifted left by 16. A new offset is latched only at restart, or on the step that brings the frequency from k = 1 back to k = 0.
- R10: The table index p is phase bits [31:22]. The quadrant is q = p[9:8] and f = p[7:0]. Let x = f for q = 0 or 2, and x = 256 - f for q = 1 or 3. The magnitude is floor(2047*x*(512-x)/65536), and it is negated for q = 2 or 3. The sample register shows, one cycle later, the value for the phase of the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance ramp, dwell and phase |
| restart | input | 1 | Synchronous sweep restart and configuration load |
| start_freq | input | 32 | Base frequency word |
| step_freq | input | 32 | Frequency increment per step |
| step_count | input | CW | Steps per ramp direction |
| phase_a | input | 16 | Phase offset for channel A |
| phase_b | input | 16 | Phase offset for channel B |
| sample_a | output | 12 | Channel A sine sample, two's complement |
| sample_b | output | 12 | Channel B sine sample, two's complement |
| freq_word | output | 32 | Current frequency word |
| dir_up | output | 1 | 1 while the sweep is rising |

## Verification
The bench builds the block with DWELL = 3 and CW = 8 instead of the defaults of 1 and 17. A multi-cycle dwell exercises the dwell counter, which a single-cycle dwell would hide. Step counts of 0 to 6 bring many reversals at both ends, and offset adoption at the base, within a few thousand cycles. A base word just below 2^32 exercises modular wrap of the frequency word. Offset changes in the middle of a sweep check that channel B keeps its old phase until the ramp next returns to its base.

// File: rtl/chirp_pkg.sv
package chirp_pkg;

    typedef enum logic [1:0] {
        QD_RISE  = 2'd0,
        QD_FALL  = 2'd1,
        QD_NRISE = 2'd2,
        QD_NFALL = 2'd3
    } quad_e;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    // Quadrants that read the quarter wave backwards
    function automatic logic quad_mirrored(quad_e q);
        return (q == QD_FALL) || (q == QD_NFALL);
    endfunction

    // Quadrants in the negative half cycle
    function automatic logic quad_negative(quad_e q);
        return (q == QD_NRISE) || (q == QD_NFALL);
    endfunction

endpackage

// File: rtl/chirp_ramp.sv
module chirp_ramp
    import chirp_pkg::*;
#(
    parameter int FW    = 32,
    parameter int CW    = 17,
    parameter int DWELL = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          restart,
    input  logic [FW-1:0] start_i,
    input  logic [FW-1:0] step_i,
    input  logic [CW-1:0] count_i,
    output logic [FW-1:0] freq_o,
    output logic          dir_up_o,
    output logic          upramp_start_o
);

    localparam int DWW = (DWELL > 1) ? $clog2(DWELL) : 1;
    localparam logic [DWW-1:0] DW_LAST = DWW'(DWELL - 1);

    typedef struct packed {
        logic [FW-1:0] base;
        logic [FW-1:0] inc;
        logic [CW-1:0] lim;
    } cfg_t;

    typedef struct packed {
        logic [FW-1:0] freq;
        logic [CW-1:0] idx;
        dir_e          dir;
    } st_t;

    cfg_t           cfg_q;
    st_t            st_q, st_d;
    logic [DWW-1:0] dwell_q;
    logic           dwell_last;
    logic           step_now;
    logic           top_hit;
    logic           bottom_hit;

    assign dwell_last = (dwell_q == DW_LAST);
    assign step_now   = en && dwell_last && (cfg_q.lim != '0);
    assign top_hit    = (st_q.dir == DIR_UP) && ((st_q.idx + CW'(1)) == cfg_q.lim);
    assign bottom_hit = (st_q.dir == DIR_DOWN) && (st_q.idx == CW'(1));

    always_comb begin
        st_d = st_q;
        if (step_now) begin
            if (st_q.dir == DIR_UP) begin
                st_d.freq = st_q.freq + cfg_q.inc;
                st_d.idx  = st_q.idx + CW'(1);
                if (top_hit) st_d.dir = DIR_DOWN;
            end else begin
                st_d.freq = st_q.freq - cfg_q.inc;
                st_d.idx  = st_q.idx - CW'(1);
                if (bottom_hit) st_d.dir = DIR_UP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            st_q    <= '{freq: '0, idx: '0, dir: DIR_UP};
            dwell_q <= '0;
        end else if (restart) begin
            cfg_q   <= '{base: start_i, inc: step_i, lim: count_i};
            st_q    <= '{freq: start_i, idx: '0, dir: DIR_UP};
            dwell_q <= '0;
        end else if (en) begin
            dwell_q <= dwell_last ? '0 : dwell_q + DWW'(1);
            st_q    <= st_d;
        end
    end

    assign freq_o         = st_q.freq;
    assign dir_up_o       = (st_q.dir == DIR_UP);
    assign upramp_start_o = step_now && bottom_hit && !restart;

    // R2: restart loads base and rising direction
    a_r2_restart_load: assert property (@(posedge clk) disable iff (rst)
        restart |=> (freq_o == $past(start_i)) && (st_q.dir == DIR_UP) && (st_q.idx == '0));

    // R4: no frequency change outside a completed dwell
    a_r4_hold_between: assert property (@(posedge clk) disable iff (rst)
        (!restart && !(en && dwell_last)) |=> $stable(st_q.freq));

    // R3: step index never passes the programmed count
    a_r3_idx_bound: assert property (@(posedge clk) disable iff (rst)
        st_q.idx <= cfg_q.lim);

    // R5: direction flips exactly at the end points
    a_r5_dir_flip: assert property (@(posedge clk) disable iff (rst)
        (!restart && step_now && (top_hit || bottom_hit)) |=> (st_q.dir != $past(st_q.dir)));

    a_r5_dir_keep: assert property (@(posedge clk) disable iff (rst)
        (!restart && !(step_now && (top_hit || bottom_hit))) |=> $stable(st_q.dir));

    // R7: zero count keeps the word static
    a_r7_static: assert property (@(posedge clk) disable iff (rst)
        (!restart && cfg_q.lim == '0) |=> $stable(st_q.freq));

endmodule

// File: rtl/chirp_sine_lut.sv
module chirp_sine_lut
    import chirp_pkg::*;
#(
    parameter int AW = 10,
    parameter int SW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr_i,
    output logic [SW-1:0] sample_o
);

    localparam int QB  = AW - 2;
    localparam int QSZ = 1 << QB;
    localparam int AMP = (1 << (SW - 1)) - 1;
    localparam int MW  = SW + 2 * AW;

    quad_e          qd;
    logic [QB-1:0]  frac;
    logic [QB:0]    x;
    logic [MW-1:0]  prod;
    logic [MW-1:0]  mag;
    logic [SW-1:0]  samp_d;
    logic [SW-1:0]  sample_q;

    assign qd   = quad_e'(addr_i[AW-1 -: 2]);
    assign frac = addr_i[QB-1:0];

    // Distance into the quarter wave; QSZ means the peak
    assign x = quad_mirrored(qd) ? ((QB+1)'(QSZ) - {1'b0, frac}) : {1'b0, frac};

    // Parabolic quarter-wave approximation, scaled by a power of two
    assign prod = MW'(AMP) * MW'(x) * (MW'(2 * QSZ) - MW'(x));
    assign mag  = prod >> (2 * QB);

    assign samp_d = quad_negative(qd) ? (SW'(0) - SW'(mag)) : SW'(mag);

    always_ff @(posedge clk) begin
        if (rst) sample_q <= '0;
        else     sample_q <= samp_d;
    end

    assign sample_o = sample_q;

    // R10: positive peak index gives full-scale amplitude next cycle
    a_r10_peak: assert property (@(posedge clk) disable iff (rst)
        (addr_i == {2'b01, {QB{1'b0}}}) |=> (sample_o == SW'(AMP)));

    // R10: zero crossing index gives zero next cycle
    a_r10_zero: assert property (@(posedge clk) disable iff (rst)
        (addr_i == '0) |=> (sample_o == '0));

endmodule

// File: rtl/chirp_channel.sv
module chirp_channel #(
    parameter int PW   = 32,
    parameter int OFFW = 16,
    parameter int AW   = 10,
    parameter int SW   = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    input  logic            load_i,
    input  logic [PW-1:0]   acc_i,
    input  logic [OFFW-1:0] offset_i,
    output logic [SW-1:0]   sample_o
);

    logic [OFFW-1:0] off_q;
    logic [PW-1:0]   phase;

    always_ff @(posedge clk) begin
        if (rst) off_q <= '0;
        else if (restart || load_i) off_q <= offset_i;
    end

    assign phase = acc_i + {off_q, {(PW-OFFW){1'b0}}};

    chirp_sine_lut #(.AW(AW), .SW(SW)) i_lut (
        .clk      (clk),
        .rst      (rst),
        .addr_i   (phase[PW-1 -: AW]),
        .sample_o (sample_o)
    );

    // R9: offset only changes at restart or up-ramp start
    a_r9_offset_hold: assert property (@(posedge clk) disable iff (rst)
        (!restart && !load_i) |=> $stable(off_q));

endmodule

// File: rtl/dual_chirp_nco.sv
module dual_chirp_nco
    import chirp_pkg::*;
#(
    parameter int FW    = 32,
    parameter int CW    = 17,
    parameter int DWELL = 1,
    parameter int OFFW  = 16,
    parameter int AW    = 10,
    parameter int SW    = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            restart,
    input  logic [FW-1:0]   start_freq,
    input  logic [FW-1:0]   step_freq,
    input  logic [CW-1:0]   step_count,
    input  logic [OFFW-1:0] phase_a,
    input  logic [OFFW-1:0] phase_b,
    output logic [SW-1:0]   sample_a,
    output logic [SW-1:0]   sample_b,
    output logic [FW-1:0]   freq_word,
    output logic            dir_up
);

    localparam int NCH = 2;

    logic [FW-1:0]   acc_q;
    logic            upramp_start;
    logic [OFFW-1:0] off_in [NCH];
    logic [SW-1:0]   samp   [NCH];

    chirp_ramp #(.FW(FW), .CW(CW), .DWELL(DWELL)) i_ramp (
        .clk            (clk),
        .rst            (rst),
        .en             (en),
        .restart        (restart),
        .start_i        (start_freq),
        .step_i         (step_freq),
        .count_i        (step_count),
        .freq_o         (freq_word),
        .dir_up_o       (dir_up),
        .upramp_start_o (upramp_start)
    );

    always_ff @(posedge clk) begin
        if (rst || restart) acc_q <= '0;
        else if (en)        acc_q <= acc_q + freq_word;
    end

    assign off_in[0] = phase_a;
    assign off_in[1] = phase_b;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        chirp_channel #(.PW(FW), .OFFW(OFFW), .AW(AW), .SW(SW)) i_ch (
            .clk      (clk),
            .rst      (rst),
            .restart  (restart),
            .load_i   (upramp_start),
            .acc_i    (acc_q),
            .offset_i (off_in[g]),
            .sample_o (samp[g])
        );
    end

    assign sample_a = samp[0];
    assign sample_b = samp[1];

    // R6: accumulator frozen while disabled
    a_r6_acc_freeze: assert property (@(posedge clk) disable iff (rst)
        (!en && !restart) |=> $stable(acc_q));

    // R8: accumulator advances by the present frequency word
    a_r8_acc_step: assert property (@(posedge clk) disable iff (rst)
        (en && !restart) |=> (acc_q == $past(acc_q) + $past(freq_word)));

    // R2: accumulator cleared after restart
    a_r2_acc_clear: assert property (@(posedge clk) disable iff (rst)
        restart |=> (acc_q == '0));

endmodule

// File: tb/test_dual_chirp_nco.sv
module test_dual_chirp_nco;

    localparam int DWELL = 3;
    localparam int CW    = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        restart = 1'b0;
    logic [31:0] start_freq = '0;
    logic [31:0] step_freq = '0;
    logic [CW-1:0] step_count = '0;
    logic [15:0] phase_a = '0;
    logic [15:0] phase_b = '0;
    logic [11:0] sample_a, sample_b;
    logic [31:0] freq_word;
    logic        dir_up;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5ns clk = ~clk;

    dual_chirp_nco #(.CW(CW), .DWELL(DWELL)) i_dual_chirp_nco (
        .clk(clk), .rst(rst), .en(en), .restart(restart),
        .start_freq(start_freq), .step_freq(step_freq), .step_count(step_count),
        .phase_a(phase_a), .phase_b(phase_b),
        .sample_a(sample_a), .sample_b(sample_b),
        .freq_word(freq_word), .dir_up(dir_up)
    );

    // Reference model state
    logic [31:0] m_freq, m_base, m_inc, m_acc;
    int          m_lim, m_idx, m_dw;
    bit          m_up;
    logic [15:0] m_off [2];
    logic [11:0] m_samp [2];

    function automatic logic [11:0] ref_sine(input logic [9:0] p);
        int q, f, x, mag;
        q = int'(p[9:8]);
        f = int'(p[7:0]);
        x = (q % 2 == 1) ? 256 - f : f;
        mag = (2047 * x * (512 - x)) / 65536;
        return (q >= 2) ? 12'(-mag) : 12'(mag);
    endfunction

    function automatic logic [11:0] ref_chan(input logic [31:0] acc, input logic [15:0] off);
        logic [31:0] ph;
        ph = acc + {off, 16'h0};
        return ref_sine(ph[31:22]);
    endfunction

    always @(posedge clk) begin
        logic [11:0] ns0, ns1;
        bit back_to_base;
        ns0 = ref_chan(m_acc, m_off[0]);
        ns1 = ref_chan(m_acc, m_off[1]);
        if (rst) begin
            m_freq = '0; m_base = '0; m_inc = '0; m_acc = '0;
            m_lim = 0; m_idx = 0; m_dw = 0; m_up = 1;
            m_off[0] = '0; m_off[1] = '0; m_samp[0] = '0; m_samp[1] = '0;
        end else if (restart) begin
            m_samp[0] = ns0; m_samp[1] = ns1;
            m_base = start_freq; m_inc = step_freq; m_lim = int'(step_count);
            m_freq = start_freq; m_idx = 0; m_up = 1; m_dw = 0; m_acc = '0;
            m_off[0] = phase_a; m_off[1] = phase_b;
        end else begin
            m_samp[0] = ns0; m_samp[1] = ns1;
            if (en) begin
                m_acc = m_acc + m_freq;
                back_to_base = 0;
                if (m_dw == DWELL - 1 && m_lim != 0) begin
                    if (m_up) begin
                        m_idx++; m_freq = m_freq + m_inc;
                        if (m_idx == m_lim) m_up = 0;
                    end else begin
                        m_idx--; m_freq = m_freq - m_inc;
                        if (m_idx == 0) begin m_up = 1; back_to_base = 1; end
                    end
                end
                m_dw = (m_dw == DWELL - 1) ? 0 : m_dw + 1;
                if (back_to_base) begin m_off[0] = phase_a; m_off[1] = phase_b; end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("R3 freq_word", freq_word, m_freq);
        chk("R5 dir_up", 32'(dir_up), 32'(m_up));
        chk("R8 sample_a", 32'(sample_a), 32'(m_samp[0]));
        chk("R9 sample_b", 32'(sample_b), 32'(m_samp[1]));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic do_restart(input logic [31:0] s, input logic [31:0] st, input int n,
                              input logic [15:0] oa, input logic [15:0] ob);
        start_freq = s; step_freq = st; step_count = CW'(n);
        phase_a = oa; phase_b = ob; restart = 1'b1;
        tick();
        restart = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] held;
        int gap;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 freq_word", freq_word, 32'h0);
        chk("R1 dir_up", 32'(dir_up), 32'h1);
        chk("R1 sample_a", 32'(sample_a), 32'h0);
        chk("R1 sample_b", 32'(sample_b), 32'h0);

        // R2: restart with en low still loads
        do_restart(32'h1000_0000, 32'h0100_0000, 3, 16'h0000, 16'h4000);
        chk("R2 freq after restart", freq_word, 32'h1000_0000);
        chk("R2 dir after restart", 32'(dir_up), 32'h1);

        en = 1'b1;
        // R4: first step only after DWELL enabled cycles
        for (int i = 0; i < DWELL - 1; i++) begin
            tick();
            chk("R4 held before first step", freq_word, 32'h1000_0000);
        end
        tick();
        chk("R4 first step", freq_word, 32'h1100_0000);
        // R3/R5: full triangles with count 3
        repeat (60) tick();

        // R4: measure gap between changes
        held = freq_word;
        while (freq_word == held) tick();
        held = freq_word;
        gap = 0;
        while (freq_word == held && gap < 20) begin tick(); gap++; end
        chk("R4 dwell length", 32'(gap), 32'(DWELL));

        // R6: en low freezes everything
        en = 1'b0;
        held = freq_word;
        repeat (10) tick();
        chk("R6 freq frozen", freq_word, held);
        en = 1'b1;
        repeat (10) tick();

        // R7: zero step count
        do_restart(32'h0800_0000, 32'h0010_0000, 0, 16'h1234, 16'h9234);
        repeat (25) tick();
        chk("R7 freq static", freq_word, 32'h0800_0000);
        chk("R7 dir stays up", 32'(dir_up), 32'h1);

        // R3: modular wrap with a single step
        do_restart(32'hFFFF_FF80, 32'h0000_0100, 1, 16'h8000, 16'h0000);
        repeat (30) tick();

        // R9: mid-sweep offset change adopted only at the base
        do_restart(32'h0200_0000, 32'h0040_0000, 4, 16'h0000, 16'h2000);
        repeat (4) tick();
        phase_b = 16'hC000;
        repeat (40) tick();

        // Random segments
        for (int seg = 0; seg < 30; seg++) begin
            int n;
            n = ($urandom % 8 == 0) ? 0 : 1 + int'($urandom % 6);
            do_restart($urandom, $urandom >> ($urandom % 8), n, 16'($urandom), 16'($urandom));
            for (int c = 0; c < 300; c++) begin
                en = ($urandom % 8) != 0;
                if ($urandom % 16 == 0) phase_a = 16'($urandom);
                if ($urandom % 16 == 0) phase_b = 16'($urandom);
                restart = ($urandom % 200) == 0;
                if (restart) step_count = CW'(1 + $urandom % 6);
                tick();
                restart = 1'b0;
            end
        end

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule